// File: doc/BRIEF.md
# Pipeline Reservation Table Collision Checker

This block holds two resource-by-cycle usage tables and works out, by overlaying a table on a shifted copy, which start distances between two instructions would put two claims on the same resource in the same cycle. Each table has one row per pipeline resource, such as fetch, decode, execute and write-back. Each column is one clock cycle after issue. A set bit means that resource is occupied in that cycle. Software or a scheduler loads the tables one row per cycle through a write port, then pulses a start input.

In self mode the block compares the base table with itself at every start distance from 1 up to the column count minus 1, one distance per clock. It returns a vector in which each set bit marks a forbidden latency and each clear bit marks an allowed one.

In cross mode it takes a second table, which describes an incoming instruction that would issue K cycles after the occupancy held in the base table, and reports in one clock whether that single distance K collides. The earlier occupant keeps its resources, so a collision means that the incoming instruction must wait. Results and the done flag stay unchanged until the next accepted start.

Top module: `rt_collision_checker`

## Requirements
- R1: After reset, busy_o, done_o, hit_o and every bit of vec_o are 0, and both tables are all zero.
- R2: A write with wr_en_i high stores wr_data_i as row wr_row_i of the base table (wr_bank_i=0) or of the incoming table (wr_bank_i=1). Bit c of a row is cycle c after issue.
- R3: In self mode (mode_i=0), vec_o bit K-1 is 1 exactly when some row of the base table has bits c and c-K both set, for K from 1 to COLS-1.
- R4: A self-mode run holds busy_o high from the edge that accepts start_i. It raises done_o and drops busy_o COLS-1 clocks after that edge, and done_o and busy_o are never high together.
- R5: In cross mode (mode_i=1) with distance K=offset_i, hit_o is 1 exactly when some row r and cycle c have base bit c+K and incoming bit c both set. In that mode vec_o is all zero, and done_o rises one clock after the accepting edge.
- R6: vec_o, hit_o and done_o hold their values until the next accepted start, even if either table is rewritten in between.
- R7: start_i while busy_o is high is ignored: the run in progress keeps its mode, distance and finishing cycle.
- R8: In cross mode an offset of 0 compares the two tables unshifted, so identical non-empty tables collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Row write strobe |
| wr_bank_i | input | 1 | 0 selects the base table, 1 selects the incoming table |
| wr_row_i | input | RW | Resource row to write |
| wr_data_i | input | COLS | Row usage, bit c = cycle c |
| start_i | input | 1 | Begin evaluation (accepted when not busy) |
| mode_i | input | 1 | 0 self overlay, 1 cross check |
| offset_i | input | OW | Start distance for cross mode |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | Results valid |
| vec_o | output | COLS-1 | Bit K-1 set = distance K forbidden (self mode) |
| hit_o | output | 1 | Cross-mode collision at offset_i |

## Verification
A self-mode result arrives COLS-1 clocks after the edge that accepts the start, and a cross-mode result arrives one clock after it. The driver stamps every expected item with the clock count at that accepting edge and with the latency its mode implies. The monitor pops the item when done_o rises and checks the arrival cycle as well as the vector and hit bit. The hold and ignored-start cases are checked by sampling the outputs for several clocks after the stimulus that could have disturbed them, before the next start is issued.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SELF  = 2'd1,
    ST_CROSS = 2'd2
  } rt_state_e;
endpackage

// File: rtl/rt_table_store.sv
module rt_table_store #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       wr_bank_i,
  input  logic [RW-1:0]              wr_row_i,
  input  logic [COLS-1:0]            wr_data_i,
  output logic [ROWS-1:0][COLS-1:0]  base_o,
  output logic [ROWS-1:0][COLS-1:0]  inc_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic sel;
    assign sel = wr_en_i && (wr_row_i == RW'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[r] <= '0;
        inc_o[r]  <= '0;
      end else if (sel) begin
        if (wr_bank_i) inc_o[r]  <= wr_data_i;
        else           base_o[r] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/rt_overlap.sv
module rt_overlap #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int OW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [ROWS-1:0][COLS-1:0] occ_i,
  input  logic [ROWS-1:0][COLS-1:0] new_i,
  input  logic [OW-1:0]             off_i,
  output logic                      hit_o
);
  logic [ROWS-1:0] row_hit;

  // later instruction's cycle c lands on occupancy cycle c+off
  for (genvar r = 0; r < ROWS; r++) begin : g_cmp
    logic [COLS-1:0] shifted;
    assign shifted   = new_i[r] << off_i;
    assign row_hit[r] = |(occ_i[r] & shifted);
  end

  assign hit_o = |row_hit;
endmodule

// File: rtl/rt_seq.sv
module rt_seq
  import rt_pkg::*;
#(
  parameter int COLS = 8,
  localparam int OW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            mode_i,
  input  logic [OW-1:0]   offset_i,
  input  logic            coll_i,
  output logic [OW-1:0]   eval_off_o,
  output logic            cross_sel_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [COLS-2:0] vec_o,
  output logic            hit_o
);
  localparam logic [OW-1:0] K_LAST = OW'(COLS - 1);
  localparam logic [OW-1:0] K_ONE  = OW'(1);

  rt_state_e      st_q;
  logic [OW-1:0]  k_q;
  logic [OW-1:0]  off_q;
  logic [OW-1:0]  km1;

  assign km1         = k_q - K_ONE;
  assign eval_off_o  = (st_q == ST_CROSS) ? off_q : k_q;
  assign cross_sel_o = (st_q == ST_CROSS);
  assign busy_o      = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      off_q  <= '0;
      vec_o  <= '0;
      hit_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            done_o <= 1'b0;
            vec_o  <= '0;
            hit_o  <= 1'b0;
            off_q  <= offset_i;
            k_q    <= K_ONE;
            st_q   <= mode_i ? ST_CROSS : ST_SELF;
          end
        end
        ST_SELF: begin
          vec_o[km1] <= coll_i;
          if (k_q == K_LAST) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end else begin
            k_q <= k_q + K_ONE;
          end
        end
        ST_CROSS: begin
          hit_o  <= coll_i;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R4
  self_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SELF && k_q == K_LAST) |=> (done_o && !busy_o));
  // R5
  cross_one_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CROSS) |=> (done_o && !busy_o));
  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(vec_o) && $stable(hit_o)));
  // R7
  busy_start_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SELF && k_q != K_LAST && start_i) |=> (st_q == ST_SELF && k_q == $past(k_q) + K_ONE));
endmodule

// File: rtl/rt_collision_checker.sv
module rt_collision_checker #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int OW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_bank_i,
  input  logic [RW-1:0]   wr_row_i,
  input  logic [COLS-1:0] wr_data_i,
  input  logic            start_i,
  input  logic            mode_i,
  input  logic [OW-1:0]   offset_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [COLS-2:0] vec_o,
  output logic            hit_o
);
  logic [ROWS-1:0][COLS-1:0] base_tab;
  logic [ROWS-1:0][COLS-1:0] inc_tab;
  logic [ROWS-1:0][COLS-1:0] new_tab;
  logic [OW-1:0]             eval_off;
  logic                      cross_sel;
  logic                      coll;

  rt_table_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_bank_i (wr_bank_i),
    .wr_row_i  (wr_row_i),
    .wr_data_i (wr_data_i),
    .base_o    (base_tab),
    .inc_o     (inc_tab)
  );

  // self mode overlays base on itself
  assign new_tab = cross_sel ? inc_tab : base_tab;

  rt_overlap #(.ROWS(ROWS), .COLS(COLS)) u_overlap (
    .occ_i (base_tab),
    .new_i (new_tab),
    .off_i (eval_off),
    .hit_o (coll)
  );

  rt_seq #(.COLS(COLS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .offset_i    (offset_i),
    .coll_i      (coll),
    .eval_off_o  (eval_off),
    .cross_sel_o (cross_sel),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .vec_o       (vec_o),
    .hit_o       (hit_o)
  );
endmodule

// File: tb/rt_collision_checker_test.sv
module rt_collision_checker_test;
  localparam int R = 4;
  localparam int C = 8;
  localparam int RW = $clog2(R);
  localparam int OW = $clog2(C);
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_bank = 1'b0;
  logic [RW-1:0] wr_row = '0;
  logic [C-1:0]  wr_data = '0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [OW-1:0] offset = '0;
  logic          busy, done, hit;
  logic [C-2:0]  vec;

  rt_collision_checker #(.ROWS(R), .COLS(C)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_bank_i(wr_bank),
    .wr_row_i(wr_row), .wr_data_i(wr_data), .start_i(start), .mode_i(mode),
    .offset_i(offset), .busy_o(busy), .done_o(done), .vec_o(vec), .hit_o(hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [C-2:0] vec;
    logic         hit;
    int           lat;
    int           t0;
    string        tag;
  } item_t;

  item_t        sb[$];
  logic [C-1:0] bt [2][R];
  int           cyc = 0;
  int           n_chk = 0;
  int           n_fail = 0;
  logic         prev_done = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [C-2:0] ref_self();
    logic [C-2:0] v = '0;
    for (int k = 1; k < C; k++)
      for (int r = 0; r < R; r++)
        for (int c = k; c < C; c++)
          if (bt[0][r][c] && bt[0][r][c-k]) v[k-1] = 1'b1;
    return v;
  endfunction

  function automatic logic ref_cross(int k);
    logic h = 1'b0;
    for (int r = 0; r < R; r++)
      for (int c = 0; c + k < C; c++)
        if (bt[0][r][c+k] && bt[1][r][c]) h = 1'b1;
    return h;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && done && !prev_done) begin
      if (sb.size() == 0) begin
        chk("R7 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk({it.tag, " vec"}, vec, it.vec);
        chk({it.tag, " hit"}, hit, it.hit);
        chk({it.tag, " latency"}, cyc - it.t0, it.lat);
      end
    end
    prev_done = done;
  end

  task automatic wr(bit bank, int row, logic [C-1:0] d);
    wr_en = 1'b1; wr_bank = bank; wr_row = RW'(row); wr_data = d;
    bt[bank][row] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(bit m, int k, string tag, bit dbl);
    item_t it;
    it.vec = m ? '0 : ref_self();
    it.hit = m ? ref_cross(k) : 1'b0;
    it.lat = m ? 1 : C - 1;
    it.t0  = cyc + 1;
    it.tag = tag;
    sb.push_back(it);
    start = 1'b1; mode = m; offset = OW'(k);
    @(negedge clk);
    start = 1'b0;
    if (dbl) begin
      @(negedge clk);
      start = 1'b1; mode = 1'b1; offset = '0;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < R; r++) bt[b][r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 vec", vec, 0);
    chk("R1 hit", hit, 0);
    run(1'b0, 0, "R1 empty tables self", 1'b0);

    // R2 R3: one cycle per stage, diagonal
    for (int r = 0; r < R; r++) wr(1'b0, r, C'(1) << r);
    run(1'b0, 0, "R3 diagonal", 1'b0);
    wr(1'b0, 0, 8'b0000_0011);
    run(1'b0, 0, "R3 fetch two cycles", 1'b0);
    wr(1'b0, 2, 8'b1000_0101);
    run(1'b0, 0, "R3 execute spread", 1'b0);
    for (int r = 0; r < R; r++) wr(1'b0, r, '1);
    run(1'b0, 0, "R3 all busy", 1'b0);

    // R5 R8 cross mode
    wr(1'b0, 0, 8'b0000_1111); wr(1'b0, 1, 8'b0001_0000);
    wr(1'b0, 2, 8'b0000_0000); wr(1'b0, 3, 8'b1000_0000);
    for (int r = 0; r < R; r++) wr(1'b1, r, C'(1) << r);
    run(1'b1, 0, "R8 cross offset 0", 1'b0);
    run(1'b1, 3, "R5 cross offset 3", 1'b0);
    run(1'b1, 4, "R5 cross offset 4", 1'b0);
    run(1'b1, 7, "R5 cross offset 7", 1'b0);
    for (int r = 0; r < R; r++) wr(1'b1, r, bt[0][r]);
    run(1'b1, 0, "R8 identical tables", 1'b0);

    // R7 second start while busy
    run(1'b0, 0, "R7 restart ignored", 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 no second run", busy, 0);

    // R6 hold after rewriting tables
    begin
      logic [C-2:0] v0;
      logic         h0;
      v0 = vec; h0 = hit;
      wr(1'b0, 0, '0); wr(1'b0, 3, '0); wr(1'b1, 1, '1);
      repeat (4) @(negedge clk);
      chk("R6 vec held", vec, v0);
      chk("R6 hit held", hit, h0);
      chk("R6 done held", done, 1);
    end
    run(1'b0, 0, "R2 rewritten rows", 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule